// File: doc/BRIEF.md
# Timer Capture/Compare Array

This block provides two up-counting time bases and a bank of dual-purpose channel registers. Each channel is tied to one of the two timers and has one pin. In capture mode a chosen edge on the pin stores the timer value. In compare mode the channel watches the timer and acts when the timer reaches the stored value: it raises an interrupt, drives its pin, or does both. Each timer reloads from its own reload register when it passes its all-ones value. Timer 0 advances either on a prescaled clock-enable pulse or on rising edges of an external count input. Timer 1 advances only on the prescaled enable.

Software reaches every register through a flat write/read port. A write commits on the clock edge. A read returns data combinationally. Each channel raises its own single-cycle interrupt pulse. A lower-half channel can be paired with the channel half the array above it, so that matches on either register toggle the lower channel's pin. Waveforms with two programmable edges per period are made this way.

Top module: `ccu_array`

## Requirements
- R1: After reset the following all read zero: every value register, every channel configuration, both counts, both reloads and the control register (both timers stopped). All pins and interrupt outputs are low.
- R2: Timer behaviour is set by the control register. Bit 0 runs timer 0. Bit 1 selects its source: 0 is `presc_tick`, 1 is rising edges of `t0_ext_in` after a two-flop synchronizer. Bit 2 runs timer 1 from `presc_tick`. A timer that is running advances by one at each selected event. Otherwise it holds its value. A bus write to a count register takes priority over an advance in the same cycle.
- R3: A timer that advances from all-ones loads its reload value instead. This event is the timer's overflow.
- R4: Configuration mode 1 is capture. The edge field is bits 4:3 of the configuration: 01 selects rising edges, 10 falling edges, 11 both and 00 none. The pin passes through a two-flop synchronizer. A selected edge copies the allocated timer's current count into the value register and pulses the channel's interrupt. A capture wins over a bus write to the same value register in the same cycle.
- R5: A match is the cycle after the allocated timer advances onto a count equal to the value register. Mode 2 pulses the interrupt on every match and keeps the pin low. Mode 0 is off: no interrupt and a low pin. Modes 1, 2 and 4 also keep the pin low.
- R6: Mode 3 toggles the pin and pulses the interrupt on every match.
- R7: Mode 4 pulses the interrupt on the first match only. It is re-armed by an overflow of the allocated timer. A match on the step that overflows fires.
- R8: Mode 5 sets the pin high and pulses the interrupt on the first match after re-arming, and clears the pin on overflow. If a match and an overflow happen on the same step, the pin goes high.
- R9: Mode 6 on lower channel n (n < N/2) pairs it with channel n+N/2. Both registers compare against the timer selected for channel n. Pin n toggles on a match of either register, and only once when both match together. Each register pulses its own interrupt on its own match. The upper channel's pin is held low and its own configuration is ignored. Mode 6 on an upper channel toggles on its own matches only.
- R10: The address map is as follows. Value registers are at 0..N-1. Configurations are at N..2N-1, with mode in bits 2:0, edge in bits 4:3 and timer select in bit 5 (0 = timer 0). Timer 0 count and reload are at 2N and 2N+1, timer 1 count and reload at 2N+2 and 2N+3, and control at 2N+4. Each register reads back what was written. Channels follow only their selected timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| presc_tick | input | 1 | Prescaled count enable for both timers |
| t0_ext_in | input | 1 | External count input for timer 0 |
| bus_we | input | 1 | Register write strobe |
| bus_waddr | input | clog2(2N+5) | Write address |
| bus_wdata | input | TW | Write data |
| bus_raddr | input | clog2(2N+5) | Read address |
| bus_rdata | output | TW | Read data, combinational |
| cap_in | input | N | Per-channel capture pins |
| cmp_out | output | N | Per-channel compare pins |
| irq | output | N | Per-channel interrupt pulses |

## Verification
Two collisions are provoked on purpose. The first is a capture edge that reaches the channel in the same cycle as a software write to the same value register. The bench places the write strobe exactly two edges after driving the pin, and requires the captured count to survive. The second is a timer overflow that coincides with a compare match in the once-per-period modes. Here a value equal to the reload must fire on every reload step, and in the set/clear mode it must leave the pin high rather than cleared. Both are judged against an arithmetic model of the timer sequence, which is checked pin pattern by pin pattern after every step and by interrupt totals at the end.

// File: rtl/ccu_pkg.sv
package ccu_pkg;
   typedef enum logic [2:0] {
      MD_OFF     = 3'd0,
      MD_CAP     = 3'd1,
      MD_IRQ_ALL = 3'd2,
      MD_TGL     = 3'd3,
      MD_IRQ_ONE = 3'd4,
      MD_SET_CLR = 3'd5,
      MD_DUAL    = 3'd6,
      MD_RSV     = 3'd7
   } ccu_mode_e;

   // bit 5 timer select, bits 4:3 edge select, bits 2:0 mode
   typedef struct packed {
      logic       tsel;
      logic [1:0] edge_sel;
      ccu_mode_e  mode;
   } ccu_cfg_t;

   localparam int CFG_W = 6;
endpackage

// File: rtl/ccu_timer.sv
module ccu_timer #(
   parameter int TW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   input  logic          wr_cnt,
   input  logic          wr_rel,
   input  logic [TW-1:0] wdata,
   output logic [TW-1:0] cnt,
   output logic [TW-1:0] rel,
   output logic          step,
   output logic          ovf
);
   localparam logic [TW-1:0] TOP = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         rel  <= '0;
         step <= 1'b0;
         ovf  <= 1'b0;
      end else begin
         step <= adv && !wr_cnt;
         ovf  <= adv && !wr_cnt && (cnt == TOP);
         if (wr_rel) rel <= wdata;
         if (wr_cnt) cnt <= wdata;
         else if (adv) cnt <= (cnt == TOP) ? rel : cnt + 1'b1;
      end
   end
endmodule

// File: rtl/ccu_chan.sv
module ccu_chan
   import ccu_pkg::*;
#(
   parameter int TW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  ccu_cfg_t      cfg,
   input  logic          partner,
   input  logic          peer_hit,
   input  logic          cap_pin,
   input  logic [TW-1:0] tval,
   input  logic          tstep,
   input  logic          tovf,
   input  logic          wr_val,
   input  logic [TW-1:0] wdata,
   output logic [TW-1:0] val,
   output logic          hit,
   output logic          pin,
   output logic          irq
);
   logic [2:0] sy;
   logic       rise, fall, cap_evt, cmp_on, once_on, fire_once, armed, pin_nx;

   always_comb begin
      case (cfg.mode)
         MD_IRQ_ALL, MD_TGL, MD_IRQ_ONE, MD_SET_CLR, MD_DUAL: cmp_on = 1'b1;
         default:                                             cmp_on = partner;
      endcase
      once_on = !partner && (cfg.mode == MD_IRQ_ONE || cfg.mode == MD_SET_CLR);
   end

   assign hit       = cmp_on && tstep && (tval == val);
   assign fire_once = hit && (armed || tovf);
   assign rise      = sy[1] & ~sy[2];
   assign fall      = ~sy[1] & sy[2];
   assign cap_evt   = !partner && (cfg.mode == MD_CAP) &&
                      ((cfg.edge_sel[0] && rise) || (cfg.edge_sel[1] && fall));

   always_comb begin
      pin_nx = 1'b0;
      if (!partner) begin
         case (cfg.mode)
            MD_TGL:     pin_nx = pin ^ hit;
            MD_SET_CLR: pin_nx = fire_once ? 1'b1 : (tovf ? 1'b0 : pin);
            MD_DUAL:    pin_nx = pin ^ (hit | peer_hit);
            default:    pin_nx = 1'b0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sy    <= '0;
         val   <= '0;
         armed <= 1'b1;
         pin   <= 1'b0;
         irq   <= 1'b0;
      end else begin
         sy  <= {sy[1:0], cap_pin};
         pin <= pin_nx;
         irq <= cap_evt | (once_on ? fire_once : hit);
         if (tovf) armed <= 1'b1;
         if (once_on && fire_once) armed <= 1'b0;
         if (cap_evt) val <= tval;
         else if (wr_val) val <= wdata;
      end
   end
endmodule

// File: rtl/ccu_array.sv
module ccu_array
   import ccu_pkg::*;
#(
   parameter int N  = 16,
   parameter int TW = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       presc_tick,
   input  logic                       t0_ext_in,
   input  logic                       bus_we,
   input  logic [$clog2(2*N+5)-1:0]   bus_waddr,
   input  logic [TW-1:0]              bus_wdata,
   input  logic [$clog2(2*N+5)-1:0]   bus_raddr,
   output logic [TW-1:0]              bus_rdata,
   input  logic [N-1:0]               cap_in,
   output logic [N-1:0]               cmp_out,
   output logic [N-1:0]               irq
);
   localparam int AW = $clog2(2*N+5);
   localparam int IW = $clog2(N);
   localparam int H  = N / 2;
   localparam logic [AW-IW-1:0] RG_VAL = '0;
   localparam logic [AW-IW-1:0] RG_CFG = (AW-IW)'(1);
   localparam logic [AW-1:0] A_CTL = AW'(2*N + 4);

   if (N < 2 || (1 << IW) != N) begin : g_bad_n
      $error("ccu_array: N must be a power of two, at least 2");
   end
   if (TW < 8) begin : g_bad_tw
      $error("ccu_array: TW must be at least 8");
   end

   ccu_cfg_t               cfg_q [N];
   logic [2:0]             ctl_q;
   logic [2:0]             ext_sy;
   logic                   ext_rise;
   logic [1:0][TW-1:0]     t_cnt, t_rel;
   logic [1:0]             t_step, t_ovf, t_adv, t_wr, t_wrr;
   logic [N-1:0][TW-1:0]   vals;
   logic [N-1:0]           hit, role, peer, tsel_eff, we_val;
   logic [N-1:0][2:0]      mode_vec;
   logic                   wr_cfg;

   assign wr_cfg = bus_we && (bus_waddr[AW-1:IW] == RG_CFG);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) cfg_q[i] <= '0;
         ctl_q  <= '0;
         ext_sy <= '0;
      end else begin
         ext_sy <= {ext_sy[1:0], t0_ext_in};
         if (bus_we && bus_waddr == A_CTL) ctl_q <= bus_wdata[2:0];
         if (wr_cfg) cfg_q[bus_waddr[IW-1:0]] <= ccu_cfg_t'(bus_wdata[CFG_W-1:0]);
      end
   end

   assign ext_rise = ext_sy[1] & ~ext_sy[2];
   assign t_adv[0] = ctl_q[0] && (ctl_q[1] ? ext_rise : presc_tick);
   assign t_adv[1] = ctl_q[2] && presc_tick;

   for (genvar t = 0; t < 2; t++) begin : g_tmr
      assign t_wr[t]  = bus_we && (bus_waddr == AW'(2*N + 2*t));
      assign t_wrr[t] = bus_we && (bus_waddr == AW'(2*N + 2*t + 1));
      ccu_timer #(.TW(TW)) u_tmr (
         .clk(clk), .rst_n(rst_n), .adv(t_adv[t]), .wr_cnt(t_wr[t]),
         .wr_rel(t_wrr[t]), .wdata(bus_wdata), .cnt(t_cnt[t]), .rel(t_rel[t]),
         .step(t_step[t]), .ovf(t_ovf[t])
      );
   end

   for (genvar i = 0; i < N; i++) begin : g_ch
      if (i < H) begin : g_lo
         assign role[i]     = 1'b0;
         assign tsel_eff[i] = cfg_q[i].tsel;
         assign peer[i]     = hit[i+H];
      end else begin : g_hi
         assign role[i]     = (cfg_q[i-H].mode == MD_DUAL);
         assign tsel_eff[i] = role[i] ? cfg_q[i-H].tsel : cfg_q[i].tsel;
         assign peer[i]     = 1'b0;
      end
      assign we_val[i]   = bus_we && (bus_waddr[AW-1:IW] == RG_VAL) &&
                           (bus_waddr[IW-1:0] == IW'(i));
      assign mode_vec[i] = cfg_q[i].mode;
      ccu_chan #(.TW(TW)) u_ch (
         .clk(clk), .rst_n(rst_n), .cfg(cfg_q[i]), .partner(role[i]),
         .peer_hit(peer[i]), .cap_pin(cap_in[i]), .tval(t_cnt[tsel_eff[i]]),
         .tstep(t_step[tsel_eff[i]]), .tovf(t_ovf[tsel_eff[i]]),
         .wr_val(we_val[i]), .wdata(bus_wdata), .val(vals[i]), .hit(hit[i]),
         .pin(cmp_out[i]), .irq(irq[i])
      );
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_raddr[AW-1:IW] == RG_VAL) bus_rdata = vals[bus_raddr[IW-1:0]];
      else if (bus_raddr[AW-1:IW] == RG_CFG) bus_rdata = TW'(cfg_q[bus_raddr[IW-1:0]]);
      else if (bus_raddr == AW'(2*N))     bus_rdata = t_cnt[0];
      else if (bus_raddr == AW'(2*N + 1)) bus_rdata = t_rel[0];
      else if (bus_raddr == AW'(2*N + 2)) bus_rdata = t_cnt[1];
      else if (bus_raddr == AW'(2*N + 3)) bus_rdata = t_rel[1];
      else if (bus_raddr == A_CTL)        bus_rdata = TW'(ctl_q);
   end
endmodule

// File: rtl/ccu_array_chk.sv
module ccu_array_chk
   import ccu_pkg::*;
#(
   parameter int N  = 16,
   parameter int TW = 16
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [1:0][TW-1:0]       t_cnt,
   input logic [1:0][TW-1:0]       t_rel,
   input logic [1:0]               t_adv,
   input logic [1:0]               t_wr,
   input logic [N-1:0][2:0]        mode_vec,
   input logic [N-1:0]             cmp_out,
   input logic [N-1:0]             irq
);
   localparam int H = N / 2;
   localparam logic [TW-1:0] TOP = '1;

   for (genvar t = 0; t < 2; t++) begin : g_t
      AST_TMR_INC: assert property (@(posedge clk) disable iff (!rst_n)
         (t_adv[t] && !t_wr[t] && t_cnt[t] != TOP) |=> (t_cnt[t] == $past(t_cnt[t]) + 1'b1)); // R2
      AST_TMR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         (!t_adv[t] && !t_wr[t]) |=> $stable(t_cnt[t])); // R2
      AST_TMR_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
         (t_adv[t] && !t_wr[t] && t_cnt[t] == TOP) |=> (t_cnt[t] == $past(t_rel[t]))); // R3
   end

   for (genvar i = 0; i < N; i++) begin : g_c
      AST_QUIET_PIN: assert property (@(posedge clk) disable iff (!rst_n)
         (mode_vec[i] == MD_OFF || mode_vec[i] == MD_CAP || mode_vec[i] == MD_IRQ_ALL ||
          mode_vec[i] == MD_IRQ_ONE || mode_vec[i] == MD_RSV) |=> !cmp_out[i]); // R5
      if (i < H) begin : g_lo
         AST_OFF_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_vec[i] == MD_OFF) |=> !irq[i]); // R5
         AST_PARTNER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_vec[i] == MD_DUAL) |=> !cmp_out[i+H]); // R9
      end
   end
endmodule

bind ccu_array ccu_array_chk #(.N(N), .TW(TW)) u_chk (
   .clk(clk), .rst_n(rst_n), .t_cnt(t_cnt), .t_rel(t_rel), .t_adv(t_adv),
   .t_wr(t_wr), .mode_vec(mode_vec), .cmp_out(cmp_out), .irq(irq)
);

// File: tb/ccu_array_bench.sv
module ccu_array_bench;
   localparam int N = 16, TW = 8, H = N / 2, AW = $clog2(2*N+5);
   localparam int A_T0C = 2*N, A_T0R = 2*N+1, A_T1C = 2*N+2, A_T1R = 2*N+3, A_CTL = 2*N+4;
   localparam int M_OFF = 0, M_CAP = 1, M_ALL = 2, M_TGL = 3, M_ONE = 4, M_SC = 5, M_DUAL = 6;

   logic clk = 1'b0, rst_n = 1'b0, presc_tick = 1'b0, t0_ext_in = 1'b0, bus_we = 1'b0;
   logic [AW-1:0] bus_waddr = '0, bus_raddr = '0;
   logic [TW-1:0] bus_wdata = '0, bus_rdata;
   logic [N-1:0]  cap_in = '0, cmp_out, irq;

   ccu_array #(.N(N), .TW(TW)) u_ccu_array (
      .clk(clk), .rst_n(rst_n), .presc_tick(presc_tick), .t0_ext_in(t0_ext_in),
      .bus_we(bus_we), .bus_waddr(bus_waddr), .bus_wdata(bus_wdata),
      .bus_raddr(bus_raddr), .bus_rdata(bus_rdata), .cap_in(cap_in),
      .cmp_out(cmp_out), .irq(irq)
   );

   always #5 clk = ~clk;

   int total = 0, bad = 0, rv = 0;
   int irq_cnt [N];
   int base [N];
   bit done = 1'b0;
   int m_mode [N], m_val [N], m_ts [N], m_arm [N], m_pin [N], m_irq [N];
   int m_t = 0, m_rel = 0;

   always @(negedge clk) if (rst_n) for (int i = 0; i < N; i++) if (irq[i]) irq_cnt[i]++;

   task automatic check(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk); bus_we = 1'b1; bus_waddr = AW'(a); bus_wdata = TW'(d);
      @(negedge clk); bus_we = 1'b0;
   endtask

   task automatic rd(input int a, output int d);
      @(negedge clk); bus_raddr = AW'(a); #1; d = int'(bus_rdata);
   endtask

   function automatic int cfgw(input int md, input int es, input int ts);
      return ts*32 + es*8 + md;
   endfunction

   task automatic ticks(input int n);
      @(negedge clk); presc_tick = 1'b1;
      repeat (n) @(negedge clk);
      presc_tick = 1'b0;
   endtask

   function automatic int tmr_after(input int c, input int r, input int n);
      return r + ((c - r + n) % (256 - r));
   endfunction

   task automatic model_step();
      int h [N];
      bit ovf;
      ovf = (m_t == 255);
      m_t = ovf ? m_rel : m_t + 1;
      for (int i = 0; i < N; i++) begin
         bit rl; int ts;
         rl = (i >= H) && (m_mode[i-H] == M_DUAL);
         ts = rl ? m_ts[i-H] : m_ts[i];
         h[i] = (ts == 0 && m_t == m_val[i] && (rl || (m_mode[i] >= M_ALL && m_mode[i] <= M_DUAL))) ? 1 : 0;
      end
      for (int i = 0; i < N; i++) begin
         bit rl;
         rl = (i >= H) && (m_mode[i-H] == M_DUAL);
         if (rl) begin m_irq[i] += h[i]; m_pin[i] = 0; end
         else case (m_mode[i])
            M_ALL: begin m_irq[i] += h[i]; m_pin[i] = 0; end
            M_TGL: begin m_irq[i] += h[i]; m_pin[i] ^= h[i]; end
            M_ONE: begin
               if (ovf) m_arm[i] = 1;
               if (h[i] != 0 && m_arm[i] != 0) begin m_irq[i]++; m_arm[i] = 0; end
               m_pin[i] = 0;
            end
            M_SC: begin
               if (ovf) m_arm[i] = 1;
               if (h[i] != 0 && m_arm[i] != 0) begin m_irq[i]++; m_arm[i] = 0; m_pin[i] = 1; end
               else if (ovf) m_pin[i] = 0;
            end
            M_DUAL: begin
               m_irq[i] += h[i];
               m_pin[i] ^= (h[i] | ((i < H) ? h[i+H] : 0));
            end
            default: m_pin[i] = 0;
         endcase
      end
   endtask

   function automatic string tagfor(input int md);
      case (md)
         M_ALL: return "R5 every-match irq count";
         M_TGL: return "R6 toggle irq count";
         M_ONE: return "R7 once-per-period irq count";
         M_SC:  return "R8 set/clear irq count";
         M_DUAL: return "R9 dual irq count";
         default: return "R5 off/partner irq count";
      endcase
   endfunction

   initial begin
      #2000000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: run did not complete actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd(0, rv);      check("R1 value reg 0", rv, 0);
      rd(N+3, rv);    check("R1 config 3", rv, 0);
      rd(A_T0C, rv);  check("R1 timer0 count", rv, 0);
      rd(A_T1R, rv);  check("R1 timer1 reload", rv, 0);
      rd(A_CTL, rv);  check("R1 control", rv, 0);
      check("R1 pins", int'(cmp_out), 0);
      check("R1 irq", int'(irq), 0);

      // R10 read-back
      wr(3, 'h5A);           rd(3, rv);     check("R10 value readback", rv, 'h5A);
      wr(N+5, cfgw(3,2,1));  rd(N+5, rv);   check("R10 config readback", rv, cfgw(3,2,1));
      wr(N+5, 0);
      wr(A_T0R, 'h33);       rd(A_T0R, rv); check("R10 reload readback", rv, 'h33);

      // R2 R3 prescaled counting with reload
      wr(A_T0R, 'hF0); wr(A_T0C, 'hFA); wr(A_CTL, 1);
      ticks(20);
      rd(A_T0C, rv); check("R3 timer0 wraps to reload", rv, tmr_after('hFA, 'hF0, 20));
      rd(A_T1C, rv); check("R2 timer1 stopped", rv, 0);

      // R2 external source
      wr(A_T0R, 0); wr(A_T0C, 'h10); wr(A_CTL, 3);
      @(negedge clk); presc_tick = 1'b1;
      for (int k = 0; k < 5; k++) begin
         t0_ext_in = 1'b1; repeat (3) @(negedge clk);
         t0_ext_in = 1'b0; repeat (3) @(negedge clk);
      end
      presc_tick = 1'b0; repeat (3) @(negedge clk);
      rd(A_T0C, rv); check("R2 timer0 external edges", rv, 'h15);

      // R2 timer1
      wr(A_T1C, 'h20); wr(A_CTL, 4);
      ticks(7);
      rd(A_T1C, rv); check("R2 timer1 counts ticks", rv, 'h27);
      rd(A_T0C, rv); check("R2 timer0 holds when stopped", rv, 'h15);
      wr(A_CTL, 0);

      // R4 capture edge-select sweep
      for (int es = 0; es < 4; es++) begin
         int ch, b, expv;
         ch = es*3 + 1;
         wr(N+ch, cfgw(M_CAP, es, 0));
         wr(A_T0C, 'h40 + es);
         b = irq_cnt[ch];
         @(negedge clk); cap_in[ch] = 1'b1; repeat (4) @(negedge clk);
         wr(A_T0C, 'h80 + es);
         @(negedge clk); cap_in[ch] = 1'b0; repeat (4) @(negedge clk);
         expv = (es == 0) ? 0 : ((es >= 2) ? 'h80 + es : 'h40 + es);
         rd(ch, rv); check("R4 captured value", rv, expv);
         check("R4 capture irq count", irq_cnt[ch] - b, (es & 1) + ((es >> 1) & 1));
      end
      // R10 capture from timer1
      wr(N+13, cfgw(M_CAP, 1, 1));
      @(negedge clk); cap_in[13] = 1'b1; repeat (4) @(negedge clk);
      rd(13, rv); check("R10 capture follows timer1", rv, 'h27);

      // R4 capture beats a same-cycle bus write
      wr(N+2, cfgw(M_CAP, 1, 0)); wr(A_T0C, 'h66);
      @(negedge clk); cap_in[2] = 1'b1;
      @(negedge clk);
      @(negedge clk); bus_we = 1'b1; bus_waddr = AW'(2); bus_wdata = 'h11;
      @(negedge clk); bus_we = 1'b0;
      rd(2, rv); check("R4 capture wins over write", rv, 'h66);
      wr(2, 'h22); rd(2, rv); check("R10 plain value write", rv, 'h22);
      @(negedge clk); cap_in[2] = 1'b0; repeat (4) @(negedge clk);
      rd(2, rv); check("R4 unselected falling edge ignored", rv, 'h22);

      // compare sweep R5..R9
      for (int i = 0; i < N; i++) begin
         m_mode[i] = M_OFF; m_val[i] = 0; m_ts[i] = 0; m_arm[i] = 1; m_pin[i] = 0; m_irq[i] = 0;
      end
      m_mode[0] = M_ALL;  m_val[0] = 'hF3;
      m_mode[1] = M_TGL;  m_val[1] = 'hF5;
      m_mode[2] = M_ONE;  m_val[2] = 'hF4;
      m_mode[3] = M_SC;   m_val[3] = 'hF6;
      m_mode[4] = M_DUAL; m_val[4] = 'hF2; m_val[12] = 'hF9;
      m_mode[5] = M_ALL;  m_val[5] = 'hF3; m_ts[5] = 1;
      m_mode[6] = M_ONE;  m_val[6] = 'hF0;
      m_mode[7] = M_SC;   m_val[7] = 'hF0;
      m_mode[8] = M_OFF;  m_val[8] = 'hF3;
      for (int i = 0; i < N; i++) begin
         wr(i, m_val[i]);
         wr(N+i, cfgw(m_mode[i], 0, m_ts[i]));
      end
      wr(A_T0R, 'hF0); wr(A_T0C, 'hF0); wr(A_CTL, 1);
      m_rel = 'hF0; m_t = 'hF0;
      repeat (3) @(negedge clk);
      for (int i = 0; i < N; i++) base[i] = irq_cnt[i];
      for (int k = 1; k <= 48; k++) begin
         int ep;
         ticks(1); repeat (2) @(negedge clk);
         model_step();
         ep = 0;
         for (int i = 0; i < N; i++) ep |= (m_pin[i] << i);
         check("R6 R8 R9 pin pattern", int'(cmp_out), ep);
         if (k == 24) begin
            wr(0, 'hFA); m_val[0] = 'hFA;
            wr(1, 'hFD); m_val[1] = 'hFD;
            wr(2, 'hFB); m_val[2] = 'hFB;
            wr(3, 'hFC); m_val[3] = 'hFC;
            wr(12, 'hF2); m_val[12] = 'hF2;
         end
      end
      for (int i = 0; i < N; i++)
         check(tagfor((i >= H && m_mode[i-H] == M_DUAL) ? M_DUAL : m_mode[i]),
               irq_cnt[i] - base[i], m_irq[i]);
      check("R7 reload-step match fires each period", irq_cnt[6] - base[6], 3);
      check("R10 timer1 channel never matches", irq_cnt[5] - base[5], 0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule